// File: doc/BRIEF.md
# Two-Core Coherent Byte Cache Pair

This block holds two private write-back caches, one per core, and keeps them coherent with a three-state Modified/Shared/Invalid protocol. The two caches share one snooping bus and one backing line memory. Each core issues single-byte loads and stores by raising a request and holding it until its done strobe; loads return the byte on the shared read-data output in the same cycle as the strobe.

Only one request is in flight at a time. A fixed-priority arbiter picks the next request when the controller is idle. The controller runs four steps: snoop the peer cache, look up the local cache, fill from memory on a miss, and respond. The snoop step invalidates or downgrades the peer copy and writes a dirty peer line back. The lookup step evicts a dirty victim by writing it back. The fill step installs the line from memory.

Top module: `msi_pair_cache`

## Requirements
- R1: Every cache way holds a 2-bit coherence state encoded Invalid = 0, Shared = 1, Modified = 2; the value 3 never appears.
- R2: Address bits [3:0] pick the byte within a 16-byte line, the next IDX_W bits pick the set, and the remaining upper bits form the tag; a store to one byte leaves the other bytes of the line unchanged.
- R3: Memory reads as zero after reset; a load miss fills the line from memory and installs it Shared.
- R4: A store leaves the local line Modified with the byte merged in, and moves any copy in the other cache to Invalid, so that a later load by that core misses and returns the new byte.
- R5: A load to a line the other cache holds Modified returns the owner's current byte, writes the line to memory and leaves both copies Shared.
- R6: A load that hits a Shared or Modified line changes no coherence state.
- R7: Requests are served strictly one at a time; at most one done strobe is high in any cycle.
- R8: Each set is 2-way; an Invalid way is filled first, otherwise the least recently used way is replaced.
- R9: A Modified victim is written back to memory as a whole line before its request completes, so a later miss by either core reads the stored data.
- R10: When both cores request in the same idle cycle, core 0 is served first.
- R11: Counting rising edges from the first edge at which a request is accepted, the done strobe is high after the 3rd edge for a local hit (including a store to a Shared line) and after the 4th edge for a miss.
- R12: While and just after reset, both done strobes are low and the read data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 2 | Per-core request, held until that core's done strobe |
| we_i | input | 2 | Per-core store select (1 = store, 0 = load) |
| addr_i | input | 2 x ADDR_W | Per-core byte address |
| wdata_i | input | 2 x 8 | Per-core store byte |
| done_o | output | 2 | Per-core completion strobe, one cycle |
| rdata_o | output | 8 | Load result, valid with the done strobe |

## Verification
The assertions assume that each core holds its request, address and data unchanged until its own done strobe, and then drops the request for at least one cycle. Under that protocol, the single-owner and hit-stability properties depend only on the controller's own sequencing. The bench drives each operation from a task that waits for the strobe and idles one cycle before the next request. The dual-request case lowers each core's request in the cycle its own strobe appears.

// File: rtl/msi_pkg.sv
package msi_pkg;
    localparam logic [1:0] ST_I = 2'd0;
    localparam logic [1:0] ST_S = 2'd1;
    localparam logic [1:0] ST_M = 2'd2;

    typedef enum logic [2:0] {
        F_IDLE  = 3'd0,
        F_SNOOP = 3'd1,
        F_LOOK  = 3'd2,
        F_FILL  = 3'd3,
        F_RESP  = 3'd4
    } fsm_e;
endpackage

// File: rtl/msi_bus_arb.sv
module msi_bus_arb (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] req,
    output logic [1:0] gnt
);
    always_comb begin
        gnt = 2'b00;
        if (en) begin
            if (req[0])      gnt = 2'b01;
            else if (req[1]) gnt = 2'b10;
        end
    end

    // R10
    prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (&req)) |-> (gnt == 2'b01));
endmodule

// File: rtl/msi_line_mem.sv
module msi_line_mem #(
    parameter int LA_W   = 6,
    parameter int LINE_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [LA_W-1:0]   waddr,
    input  logic [LINE_W-1:0] wdata,
    input  logic [LA_W-1:0]   raddr,
    output logic [LINE_W-1:0] rdata
);
    localparam int LINES = 2 ** LA_W;

    logic [LINE_W-1:0] mem_q [LINES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/msi_pair_cache.sv
module msi_pair_cache #(
    parameter int ADDR_W = 10,
    parameter int IDX_W  = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             req_i,
    input  logic [1:0]             we_i,
    input  logic [1:0][ADDR_W-1:0] addr_i,
    input  logic [1:0][7:0]        wdata_i,
    output logic [1:0]             done_o,
    output logic [7:0]             rdata_o
);
    import msi_pkg::*;

    localparam int OFF_W  = 4;
    localparam int LINE_W = 8 * (2 ** OFF_W);
    localparam int SETS   = 2 ** IDX_W;
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
    localparam int LA_W   = ADDR_W - OFF_W;

    typedef struct packed {
        fsm_e                                     fsm;
        logic                                     core;
        logic                                     we;
        logic [ADDR_W-1:0]                        addr;
        logic [7:0]                               wdata;
        logic [7:0]                               rdata;
        logic [1:0][SETS-1:0][1:0][1:0]           st;
        logic [1:0][SETS-1:0][1:0][TAG_W-1:0]     tag;
        logic [1:0][SETS-1:0][1:0][LINE_W-1:0]    data;
        logic [1:0][SETS-1:0]                     lru;
    } regs_t;

    regs_t q, d;

    logic [1:0]        gnt;
    logic              c, p;
    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  tg;
    logic [6:0]        sh;
    logic [1:0]        lhit, phit;
    logic              hw, vw;
    logic [LINE_W-1:0] byte_mask, byte_ins, hit_line;
    logic              mem_we;
    logic [LA_W-1:0]   mem_wa;
    logic [LINE_W-1:0] mem_wd, mem_rd;

    assign c   = q.core;
    assign p   = ~q.core;
    assign idx = q.addr[OFF_W+IDX_W-1:OFF_W];
    assign tg  = q.addr[ADDR_W-1:OFF_W+IDX_W];
    assign sh  = {q.addr[OFF_W-1:0], 3'b000};
    assign byte_mask = {{(LINE_W-8){1'b0}}, 8'hFF} << sh;
    assign byte_ins  = {{(LINE_W-8){1'b0}}, q.wdata} << sh;

    msi_bus_arb u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (q.fsm == F_IDLE),
        .req   (req_i),
        .gnt   (gnt)
    );

    msi_line_mem #(.LA_W(LA_W), .LINE_W(LINE_W)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_wa),
        .wdata (mem_wd),
        .raddr (q.addr[ADDR_W-1:OFF_W]),
        .rdata (mem_rd)
    );

    always_comb begin
        for (int w = 0; w < 2; w++) begin
            lhit[w] = (q.st[c][idx][w] != ST_I) && (q.tag[c][idx][w] == tg);
            phit[w] = (q.st[p][idx][w] != ST_I) && (q.tag[p][idx][w] == tg);
        end
        hw = lhit[1];
        if (q.st[c][idx][0] == ST_I)      vw = 1'b0;
        else if (q.st[c][idx][1] == ST_I) vw = 1'b1;
        else                              vw = q.lru[c][idx];
        hit_line = q.data[c][idx][hw];

        d      = q;
        mem_we = 1'b0;
        mem_wa = q.addr[ADDR_W-1:OFF_W];
        mem_wd = '0;
        case (q.fsm)
            F_IDLE: begin
                if (|gnt) begin
                    d.core  = gnt[1];
                    d.we    = we_i[gnt[1]];
                    d.addr  = addr_i[gnt[1]];
                    d.wdata = wdata_i[gnt[1]];
                    d.fsm   = F_SNOOP;
                end
            end
            F_SNOOP: begin
                for (int w = 0; w < 2; w++) begin
                    if (phit[w]) begin
                        if (q.st[p][idx][w] == ST_M) begin
                            mem_we = 1'b1;
                            mem_wd = q.data[p][idx][w];
                        end
                        d.st[p][idx][w] = q.we ? ST_I : ST_S;
                    end
                end
                d.fsm = F_LOOK;
            end
            F_LOOK: begin
                if (|lhit) begin
                    if (q.we) begin
                        d.data[c][idx][hw] = (hit_line & ~byte_mask) | byte_ins;
                        d.st[c][idx][hw]   = ST_M;
                    end else begin
                        d.rdata = 8'(hit_line >> sh);
                    end
                    d.lru[c][idx] = ~hw;
                    d.fsm = F_RESP;
                end else begin
                    if (q.st[c][idx][vw] == ST_M) begin
                        mem_we = 1'b1;
                        mem_wa = {q.tag[c][idx][vw], idx};
                        mem_wd = q.data[c][idx][vw];
                    end
                    d.fsm = F_FILL;
                end
            end
            F_FILL: begin
                d.tag[c][idx][vw] = tg;
                if (q.we) begin
                    d.data[c][idx][vw] = (mem_rd & ~byte_mask) | byte_ins;
                    d.st[c][idx][vw]   = ST_M;
                end else begin
                    d.data[c][idx][vw] = mem_rd;
                    d.st[c][idx][vw]   = ST_S;
                    d.rdata            = 8'(mem_rd >> sh);
                end
                d.lru[c][idx] = ~vw;
                d.fsm = F_RESP;
            end
            F_RESP:  d.fsm = F_IDLE;
            default: d.fsm = F_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done_o[0] = (q.fsm == F_RESP) && !q.core;
    assign done_o[1] = (q.fsm == F_RESP) &&  q.core;
    assign rdata_o   = q.rdata;

    // R7
    done_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done_o));

    // R6
    hit_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.fsm == F_LOOK && !q.we && (|lhit)) |=> (q.st == $past(q.st)));

    for (genvar s = 0; s < SETS; s++) begin : g_set
        for (genvar a = 0; a < 2; a++) begin : g_wa
            for (genvar k = 0; k < 2; k++) begin : g_core
                // R1
                state_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    q.st[k][s][a] != 2'b11);
            end
            for (genvar b = 0; b < 2; b++) begin : g_wb
                // R4 R5
                single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    !(q.st[0][s][a] == ST_M && q.st[1][s][b] == ST_M &&
                      q.tag[0][s][a] == q.tag[1][s][b]));
            end
        end
    end
endmodule

// File: tb/msi_pair_cache_tb.sv
module msi_pair_cache_tb;
    localparam int ADDR_W = 10;
    localparam int NV     = 18;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [1:0]             req_i = '0;
    logic [1:0]             we_i = '0;
    logic [1:0][ADDR_W-1:0] addr_i = '0;
    logic [1:0][7:0]        wdata_i = '0;
    logic [1:0]             done_o;
    logic [7:0]             rdata_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [7:0] ref_mem [1024];

    always #2 clk = ~clk;

    msi_pair_cache #(.ADDR_W(ADDR_W), .IDX_W(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .done_o(done_o), .rdata_o(rdata_o)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            errors++;
            $display("FAIL watchdog R7 act=%0d exp=%0d", cycles, 50000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // nibbles: core, store, addr[11:0], wdata, expected latency
    localparam logic [31:0] VEC [NV] = '{
        32'h00050004,  // R3 load miss reads zero
        32'h01048044,  // R4 store miss
        32'h11050054,  // R4 peer store invalidates core 0 copy
        32'h10050003,  // R6 load hit on Modified
        32'h11048064,  // R5 peer Modified line written back
        32'h00050004,  // R5 core 1 owner supplies 05
        32'h10052003,  // R6 load hit on Shared
        32'h01052073,  // R4 store hit on Shared upgrades
        32'h10052004,  // R4 invalidated copy misses
        32'h00048004,  // R5 owner supplies 06
        32'h00080004,  // R8 fills second way
        32'h00041003,  // R8 hit marks way 0 recent
        32'h010C3094,  // R8 evicts the less recent line
        32'h00048003,  // R8 recent line kept
        32'h00080004,  // R9 dirty victim evicted
        32'h100C3004,  // R9 written-back data visible
        32'h113F5AB4,  // R2 store into top set
        32'h103F5003   // R2 load hit
    };

    string vreq [NV] = '{"R3","R4","R4","R6","R5","R5","R6","R4","R4",
                         "R5","R8","R8","R8","R8","R9","R9","R2","R2"};

    task automatic check(input string rq, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
        end
    endtask

    task automatic do_op(input logic core, input logic st, input logic [ADDR_W-1:0] a,
                         input logic [7:0] wd, input int exp_lat, input string rq);
        int lat;
        @(negedge clk);
        req_i[core] = 1'b1; we_i[core] = st; addr_i[core] = a; wdata_i[core] = wd;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!done_o[core] && lat < 20);
        check(rq, "latency R11", lat, exp_lat);
        if (!st) check(rq, "load data", int'(rdata_o), int'(ref_mem[a]));
        else     ref_mem[a] = wd;
        req_i[core] = 1'b0;
    endtask

    initial begin
        int first;
        for (int i = 0; i < 1024; i++) ref_mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        check("R12", "done in reset", int'(done_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12", "done after reset", int'(done_o), 0);
        check("R12", "rdata after reset", int'(rdata_o), 0);

        for (int v = 0; v < NV; v++) begin
            do_op(VEC[v][31:28] != 0, VEC[v][27:24] != 0, VEC[v][23:12],
                  VEC[v][11:4], int'(VEC[v][3:0]), vreq[v]);
        end

        // R2 neighbour byte of a stored byte stays zero
        do_op(1'b1, 1'b0, 10'h3F4, 8'h00, 3, "R2");

        // R10 both cores request together; R5 core 0 reads core 1's Modified byte
        @(negedge clk);
        req_i = 2'b11; we_i = 2'b00;
        addr_i[0] = 10'h3F5; addr_i[1] = 10'h050;
        first = -1;
        for (int t = 0; t < 30 && req_i != 2'b00; t++) begin
            @(negedge clk);
            check("R7", "single strobe", int'(done_o == 2'b11), 0);
            if (done_o[0]) begin
                if (first < 0) first = 0;
                check("R5", "core0 data", int'(rdata_o), 8'hAB);
                req_i[0] = 1'b0;
            end
            if (done_o[1]) begin
                if (first < 0) first = 1;
                check("R10", "core1 data", int'(rdata_o), int'(ref_mem[10'h050]));
                req_i[1] = 1'b0;
            end
        end
        check("R10", "first served", first, 0);
        check("R10", "both served", int'(req_i), 0);

        // R6 owner keeps Shared copy after downgrade: still a hit
        do_op(1'b1, 1'b0, 10'h3F5, 8'h00, 3, "R6");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule